// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Timing

This block is an 18-bit first-in first-out buffer whose write side and read side each run on their own free-running clock. The two clocks may be unrelated or may be one and the same net. A word enters on a rising write-clock edge when the write enable is high. It leaves on a rising read-clock edge when the read enable is high. Pointers cross between the two domains in Gray code through two-flop synchronisers. The full/input-ready, almost-full and half-full flags are computed on the write side. The empty/output-ready and almost-empty flags are computed on the read side.

The read timing is chosen while reset is applied, from the `fwft_sel` input. In standard timing (`fwft_sel`=0) a word reaches the output only through an explicit read. In fall-through timing (`fwft_sel`=1) the oldest word is presented at the output by itself, and a read enable consumes it. The two fixed flags change meaning with the mode. The almost-empty and almost-full thresholds take default values at reset and can be reloaded at run time through a load input. A tri-state output enable gates the data output. The depth must be a power of two.

Top module: `dcfifo_ft`

## Requirements
- R1: In standard mode (`fwft_sel`=0 at reset), `q` changes only on a read-clock edge where `re`=1 and the buffer holds data. `empty_or`=1 exactly when no unread word is stored.
- R2: In fall-through mode (`fwft_sel`=1 at reset), a word written to an empty buffer on write edge E appears on `q` with `empty_or`=1 (output ready) after the third read edge following E, with `re` held low. While `re` is low, `q` and `empty_or` hold.
- R3: The signal `full_ir` is 1 when DEPTH words are stored in standard mode. In fall-through mode it is 1 while space remains and 0 when the memory holds DEPTH words. A write attempted while the buffer is full is ignored and overwrites no stored word.
- R4: A read attempted while no word is available (empty in standard mode, not ready in fall-through mode) is ignored, and `q` keeps its last value.
- R5: Words leave in the order they were written, in both modes.
- R6: `half_full`=1 exactly when the stored count is greater than DEPTH/2.
- R7: `almost_empty`=1 when the stored count is at most the almost-empty offset. `almost_full`=1 when the stored count is at least DEPTH minus the almost-full offset.
- R8: After reset both offsets equal the DEF_OFS parameter. A write edge with `ld`=1 and `we`=1 loads `din[AW-1:0]` into an offset, where AW is log2(DEPTH). The first such edge after reset loads the almost-empty offset, the next loads the almost-full offset, and the sequence then alternates. These edges store no data word.
- R9: When `oe`=0, every bit of `q` is high impedance.
- R10: After reset the buffer holds no word: `half_full`=0, `almost_full`=0, `almost_empty`=1 and `q`=0. In standard mode `empty_or`=1 and `full_ir`=0. In fall-through mode `empty_or`=0 and `full_ir`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, seen by both sides |
| fwft_sel | input | 1 | Timing mode sampled during reset: 1 fall-through, 0 standard |
| wclk | input | 1 | Write clock |
| we | input | 1 | Write enable |
| ld | input | 1 | Offset load select; with `we` it writes an offset instead of data |
| din | input | 18 | Write data; low AW bits carry offset values during a load |
| rclk | input | 1 | Read clock |
| re | input | 1 | Read enable |
| oe | input | 1 | Output enable for `q` |
| q | output | 18 | Read data, high impedance when `oe`=0 |
| empty_or | output | 1 | Empty (standard) or output ready (fall-through) |
| full_ir | output | 1 | Full (standard) or input ready (fall-through) |
| almost_empty | output | 1 | Stored count at or below the almost-empty offset |
| almost_full | output | 1 | Stored count at or above DEPTH minus the almost-full offset |
| half_full | output | 1 | Stored count above DEPTH/2 |

## Verification
The hardest situation to reach is a fall-through buffer that is truly full. That state holds one word in the output register and DEPTH words in memory. The stimulus loads the output register first and then writes DEPTH further words, so an extra write that must be ignored finds no free slot. Draining that full buffer afterwards shows whether the rejected word corrupted any stored word. The flag thresholds are swept one word at a time, filling and then draining. After each step the bench waits for both synchronisers to settle, so every count from zero to DEPTH is compared with the arithmetic thresholds.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  // which offset register the next load edge writes
  typedef enum logic {
    OFS_AE = 1'b0,
    OFS_AF = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic fwft_sel,
  output logic srst_n,
  output logic mode
);
  logic s0_q, s1_q, mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  // mode captured on the edges where the synchronised reset is still low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (!s1_q)   mode_q <= fwft_sel;
  end

  assign srst_n = s1_q;
  assign mode   = mode_q;
endmodule

// File: rtl/dcfifo_gray_sync.sv
module dcfifo_gray_sync #(
  parameter int PW = 13
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] m1_q, m2_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      m1_q <= '0;
      m2_q <= '0;
    end else begin
      m1_q <= gray_in;
      m2_q <= m1_q;
    end
  end

  always_comb begin
    bin_out[PW-1] = m2_q[PW-1];
    for (int i = PW - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ m2_q[i];
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int W     = 18,
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge wclk) begin
    if (wr_en) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
  import dcfifo_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int DEF_OFS = 127,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          srst_n,
  input  logic          mode,
  input  logic          we,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic [AW:0]   rbin_s,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] ae_ofs,
  output logic          full_ir,
  output logic          almost_full,
  output logic          half_full
);
  localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF_W  = DEPTH_W >> 1;
  localparam logic [AW-1:0] DEF_V   = AW'(DEF_OFS);

  logic [AW:0]   wbin_q, wbin_d;
  logic [AW:0]   wgray_q;
  logic [AW-1:0] ae_q, ae_d, af_q, af_d;
  ofs_sel_e      sel_q, sel_d;
  logic [AW:0]   cnt;
  logic          full;

  assign cnt   = wbin_q - rbin_s;
  assign full  = (cnt == DEPTH_W);
  assign wr_en = we & ~ld & ~full;

  always_comb begin
    wbin_d = wbin_q + {{AW{1'b0}}, wr_en};
    ae_d   = ae_q;
    af_d   = af_q;
    sel_d  = sel_q;
    if (ld && we) begin
      if (sel_q == OFS_AE) begin
        ae_d  = ld_val;
        sel_d = OFS_AF;
      end else begin
        af_d  = ld_val;
        sel_d = OFS_AE;
      end
    end
  end

  always_ff @(posedge wclk or negedge srst_n) begin
    if (!srst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ae_q    <= DEF_V;
      af_q    <= DEF_V;
      sel_q   <= OFS_AE;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      ae_q    <= ae_d;
      af_q    <= af_d;
      sel_q   <= sel_d;
    end
  end

  assign waddr       = wbin_q[AW-1:0];
  assign wgray       = wgray_q;
  assign ae_ofs      = ae_q;
  assign full_ir     = mode ? ~full : full;
  assign almost_full = (cnt >= (DEPTH_W - {1'b0, af_q}));
  assign half_full   = (cnt > HALF_W);
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side #(
  parameter int W     = 18,
  parameter int DEPTH = 4096,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          rclk,
  input  logic          srst_n,
  input  logic          mode,
  input  logic          re,
  input  logic [AW:0]   wbin_s,
  input  logic [AW-1:0] ae_ofs,
  input  logic [W-1:0]  rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  dout,
  output logic          empty_or,
  output logic          almost_empty
);
  logic [AW:0]  rbin_q, rbin_d, rgray_q;
  logic [W-1:0] dout_q, dout_d;
  logic         ov_q, ov_d;
  logic         has, take;
  logic [AW:0]  cnt;

  assign has  = (rbin_q != wbin_s);
  assign take = mode ? (has & (~ov_q | re)) : (has & re);

  always_comb begin
    rbin_d = rbin_q + {{AW{1'b0}}, take};
    dout_d = take ? rdata : dout_q;
    if (!mode)      ov_d = 1'b0;
    else if (take)  ov_d = 1'b1;
    else if (re)    ov_d = 1'b0;
    else            ov_d = ov_q;
  end

  always_ff @(posedge rclk or negedge srst_n) begin
    if (!srst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      ov_q    <= 1'b0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      dout_q  <= dout_d;
      ov_q    <= ov_d;
    end
  end

  assign cnt          = wbin_s - rbin_q + {{AW{1'b0}}, ov_q};
  assign raddr        = rbin_q[AW-1:0];
  assign rgray        = rgray_q;
  assign dout         = dout_q;
  assign empty_or     = mode ? ov_q : ~has;
  assign almost_empty = (cnt <= {1'b0, ae_ofs});
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
  parameter int DEPTH   = 4096,
  parameter int DEF_OFS = 127,
  parameter int W       = 18
) (
  input  logic         rst_n,
  input  logic         fwft_sel,
  input  logic         wclk,
  input  logic         we,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         rclk,
  input  logic         re,
  input  logic         oe,
  output logic [W-1:0] q,
  output logic         empty_or,
  output logic         full_ir,
  output logic         almost_empty,
  output logic         almost_full,
  output logic         half_full
);
  localparam int AW = $clog2(DEPTH);

  logic          srst_w_n, srst_r_n, mode_w, mode_r;
  logic [AW:0]   wgray, rgray, wbin_s, rbin_s;
  logic          wr_en;
  logic [AW-1:0] waddr, raddr, ae_ofs;
  logic [W-1:0]  rdata, dout_q;

  dcfifo_rst_sync u_rs_w (.clk(wclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
                          .srst_n(srst_w_n), .mode(mode_w));
  dcfifo_rst_sync u_rs_r (.clk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
                          .srst_n(srst_r_n), .mode(mode_r));

  dcfifo_gray_sync #(.PW(AW+1)) u_w2r (.clk(rclk), .srst_n(srst_r_n),
                                       .gray_in(wgray), .bin_out(wbin_s));
  dcfifo_gray_sync #(.PW(AW+1)) u_r2w (.clk(wclk), .srst_n(srst_w_n),
                                       .gray_in(rgray), .bin_out(rbin_s));

  dcfifo_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .wr_en(wr_en), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata));

  dcfifo_wr_side #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk(wclk), .srst_n(srst_w_n), .mode(mode_w), .we(we), .ld(ld),
    .ld_val(din[AW-1:0]), .rbin_s(rbin_s), .wr_en(wr_en), .waddr(waddr),
    .wgray(wgray), .ae_ofs(ae_ofs), .full_ir(full_ir),
    .almost_full(almost_full), .half_full(half_full));

  dcfifo_rd_side #(.W(W), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .srst_n(srst_r_n), .mode(mode_r), .re(re), .wbin_s(wbin_s),
    .ae_ofs(ae_ofs), .rdata(rdata), .raddr(raddr), .rgray(rgray),
    .dout(dout_q), .empty_or(empty_or), .almost_empty(almost_empty));

  assign q = oe ? dout_q : 'z;
endmodule

// File: rtl/dcfifo_ft_chk.sv
module dcfifo_ft_chk #(
  parameter int PW = 13,
  parameter int W  = 18
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          we,
  input logic          ld,
  input logic          re,
  input logic          full_ir,
  input logic          empty_or,
  input logic          mode_w,
  input logic          mode_r,
  input logic [PW-1:0] wgray,
  input logic [W-1:0]  dout_q
);
  // R3: a write while full must not move the write pointer
  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    (we && !ld && (mode_w ? !full_ir : full_ir)) |=> $stable(wgray));

  // R8: load edges never store a data word
  a_r8_load_no_write: assert property (@(posedge wclk) disable iff (!rst_n)
    (we && ld) |=> $stable(wgray));

  // R1: standard mode output moves only on a read
  a_r1_no_fallthrough: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_r && !re) |=> $stable(dout_q));

  // R4: read while empty leaves the output alone
  a_r4_empty_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    (!mode_r && empty_or && re) |=> $stable(dout_q));

  // R2: a presented word stays until consumed
  a_r2_ready_hold: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_r && empty_or && !re) |=> (empty_or && $stable(dout_q)));
endmodule

bind dcfifo_ft dcfifo_ft_chk #(.PW(AW+1), .W(W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .we(we), .ld(ld), .re(re),
  .full_ir(full_ir), .empty_or(empty_or), .mode_w(mode_w), .mode_r(mode_r),
  .wgray(wgray), .dout_q(dout_q));

// File: tb/dcfifo_ft_bench.sv
`timescale 1ns/1ps
module dcfifo_ft_bench;
  localparam int DEPTH = 16;
  localparam int OFS   = 3;
  localparam int W     = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0, fwft_sel = 1'b0, we = 1'b0, ld = 1'b0, re = 1'b0, oe = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic empty_or, full_ir, almost_empty, almost_full, half_full;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dcfifo_ft #(.DEPTH(DEPTH), .DEF_OFS(OFS), .W(W)) u_dcfifo_ft (
    .rst_n(rst_n), .fwft_sel(fwft_sel), .wclk(clk), .we(we), .ld(ld), .din(din),
    .rclk(clk), .re(re), .oe(oe), .q(q), .empty_or(empty_or), .full_ir(full_ir),
    .almost_empty(almost_empty), .almost_full(almost_full), .half_full(half_full));

  function automatic logic [W-1:0] dat(int k);
    return W'(32'h20000 + k * 37 + 5);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(bit m);
    @(negedge clk);
    rst_n = 1'b0; fwft_sel = m; we = 0; ld = 0; re = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic push(logic [W-1:0] d);
    @(negedge clk); we = 1'b1; din = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pop;
    @(negedge clk); re = 1'b1;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic settle;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // ---- standard mode, reset state R10
    do_reset(1'b0);
    chk(empty_or == 1, "R10 empty", empty_or, 1);
    chk(full_ir == 0, "R10 full", full_ir, 0);
    chk(almost_empty == 1, "R10 ae", almost_empty, 1);
    chk(almost_full == 0, "R10 af", almost_full, 0);
    chk(half_full == 0, "R10 hf", half_full, 0);
    chk(q == 0, "R10 q", q, 0);

    // ---- fill sweep with default offsets (R6, R7, R3, R1)
    for (int n = 1; n <= DEPTH; n++) begin
      push(dat(n - 1));
      settle;
      chk(full_ir == (n == DEPTH), "R3 full", full_ir, n == DEPTH);
      chk(half_full == (n > DEPTH / 2), "R6 hf fill", half_full, n > DEPTH / 2);
      chk(almost_full == (n >= DEPTH - OFS), "R7 af fill", almost_full, n >= DEPTH - OFS);
      chk(almost_empty == (n <= OFS), "R7 ae fill", almost_empty, n <= OFS);
      chk(empty_or == 0, "R1 not empty", empty_or, 0);
      chk(q == 0, "R1 no fall-through", q, 0);
    end
    push(18'h3FFFF);  // rejected write, R3
    settle;
    chk(full_ir == 1, "R3 full after extra", full_ir, 1);

    // ---- drain sweep (R5, R6, R7, R1)
    for (int n = 1; n <= DEPTH; n++) begin
      pop;
      chk(q == dat(n - 1), "R5 order std", q, dat(n - 1));
      settle;
      chk(q == dat(n - 1), "R1 q holds", q, dat(n - 1));
      chk(empty_or == (n == DEPTH), "R1 empty drain", empty_or, n == DEPTH);
      chk(half_full == (DEPTH - n > DEPTH / 2), "R6 hf drain", half_full, DEPTH - n > DEPTH / 2);
      chk(almost_empty == (DEPTH - n <= OFS), "R7 ae drain", almost_empty, DEPTH - n <= OFS);
      chk(full_ir == 0, "R3 not full", full_ir, 0);
    end
    pop;  // read while empty, R4
    settle;
    chk(q == dat(DEPTH - 1), "R4 read empty holds", q, dat(DEPTH - 1));
    chk(empty_or == 1, "R4 still empty", empty_or, 1);

    // ---- offset load (R8, R7)
    do_reset(1'b0);
    @(negedge clk); ld = 1; we = 1; din = 18'd5;
    @(negedge clk); din = 18'd10;
    @(negedge clk); ld = 0; we = 0;
    settle;
    chk(empty_or == 1, "R8 load stores no word", empty_or, 1);
    chk(almost_empty == 1, "R8 ae at 0", almost_empty, 1);
    for (int n = 1; n <= 8; n++) begin
      push(dat(n + 40));
      settle;
      chk(almost_empty == (n <= 5), "R8 loaded ae", almost_empty, n <= 5);
      chk(almost_full == (n >= DEPTH - 10), "R8 loaded af", almost_full, n >= DEPTH - 10);
    end
    pop;
    chk(q == dat(41), "R8 first data word", q, dat(41));

    // ---- output enable R9
    @(negedge clk); oe = 1'b0;
    #1;
    chk(q === 18'bz, "R9 hi-z", q, 0);
    @(negedge clk); oe = 1'b1;
    #1;
    chk(q == dat(41), "R9 drive back", q, dat(41));

    // ---- fall-through mode (R10, R2, R3, R5, R4)
    do_reset(1'b1);
    chk(empty_or == 0, "R10 fwft not ready", empty_or, 0);
    chk(full_ir == 1, "R10 fwft input ready", full_ir, 1);
    push(dat(100));          // edge E passed
    @(negedge clk);          // after E+1
    @(negedge clk);          // after E+2
    chk(empty_or == 0, "R2 not yet ready", empty_or, 0);
    @(negedge clk);          // after E+3
    chk(empty_or == 1, "R2 ready at third edge", empty_or, 1);
    chk(q == dat(100), "R2 first word", q, dat(100));
    for (int k = 1; k <= DEPTH; k++) push(dat(100 + k));
    settle;
    chk(full_ir == 0, "R3 fwft full", full_ir, 0);
    chk(q == dat(100), "R2 q holds without read", q, dat(100));
    push(18'h3FFFF);         // rejected, R3
    settle;
    for (int k = 0; k <= DEPTH; k++) begin
      chk(empty_or == 1, "R5 fwft ready", empty_or, 1);
      chk(q == dat(100 + k), "R5 fwft order", q, dat(100 + k));
      pop;
    end
    settle;
    chk(empty_or == 0, "R4 fwft drained", empty_or, 0);
    chk(q == dat(100 + DEPTH), "R4 fwft q holds", q, dat(100 + DEPTH));
    pop;
    settle;
    chk(q == dat(100 + DEPTH), "R4 fwft read ignored", q, dat(100 + DEPTH));
    chk(full_ir == 1, "R3 fwft space again", full_ir, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule